// File: doc/BRIEF.md
# Group-Gated Interrupt Forwarding Arbiter

This block picks, for a single processor interface, the most urgent interrupt out of a set of candidates and decides whether that interrupt may be handed on. Each candidate arrives as plain vectors: a pending bit, an individual enable bit, a group bit (group 0 or group 1) and a priority value. Two control inputs enable forwarding for group 0 and for group 1.

The gating rule is strict. The arbiter first selects the overall winner among all enabled pending candidates, whatever their group. That winner is forwarded only if its own group is enabled. If the winner belongs to a disabled group, nothing is forwarded. The block does not fall back to the best candidate of the enabled group. When nothing is forwarded, the outputs show a spurious ID.

The result is registered, so the outputs follow the inputs with one clock of delay. A parameter selects how the winner is found: a balanced comparison tree or a linear scan. Both give the same result.

Top module: `irq_fwd_dist`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the block forwards nothing: fwd_valid_o is 0, fwd_id_o is 1023, fwd_prio_o is all ones and fwd_group_o is 0.
- R2: A candidate takes part in arbitration only when both its pending bit and its enable bit are 1. With no such candidate, nothing is forwarded.
- R3: Among the candidates, the one with the lowest numeric priority value wins.
- R4: When candidates have equal priority values, the one with the lowest interrupt ID wins.
- R5: When both group enables are 0, nothing is forwarded, whatever the candidates are.
- R6: When both group enables are 1, the winner is forwarded whatever its group. fwd_group_o shows the winner's group bit (0 or 1), and fwd_prio_o shows the winner's priority.
- R7: When group 0 is disabled, group 1 is enabled and the winner is in group 0, nothing is forwarded, even if lower-ranked group 1 candidates exist.
- R8: When group 0 is enabled, group 1 is disabled and the winner is in group 1, nothing is forwarded, even if lower-ranked group 0 candidates exist.
- R9: When exactly one group is enabled and the winner is in that group, the winner is forwarded.
- R10: The outputs reflect the inputs sampled at the previous rising clock edge. The block keeps no other state, so a change of configuration takes effect on the next edge.
- R11: Whenever fwd_valid_o is 0, fwd_id_o is 1023, fwd_prio_o is all ones and fwd_group_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| irq_pending_i | input | NUM_IRQ | Pending bit per interrupt |
| irq_enable_i | input | NUM_IRQ | Enable bit per interrupt |
| irq_group_i | input | NUM_IRQ | Group bit per interrupt (0 = group 0, 1 = group 1) |
| irq_prio_i | input | NUM_IRQ*PRIO_W | Priority per interrupt; interrupt i uses bits [i*PRIO_W +: PRIO_W] |
| grp0_en_i | input | 1 | Forwarding enable for group 0 |
| grp1_en_i | input | 1 | Forwarding enable for group 1 |
| fwd_valid_o | output | 1 | An interrupt is being forwarded |
| fwd_id_o | output | 10 | Forwarded interrupt ID, or 1023 when idle |
| fwd_prio_o | output | PRIO_W | Forwarded priority, or all ones when idle |
| fwd_group_o | output | 1 | Forwarded group bit, or 0 when idle |

## Verification
The assertions assume that every input holds a defined 0 or 1 value at each rising edge, including the edges during reset. This is because the checker compares the outputs with its own copy of the inputs from the previous cycle. The stimulus is applied on falling edges only, and every vector is driven from time zero. The bench uses five interrupts with a three-bit priority, so the tree has to handle padding and priority ties often. It sweeps every combination of pending, enable and group bits, varies the two group enables and the priorities with each vector, and runs both arbiter variants side by side.

// File: rtl/irq_fwd_pkg.sv
`timescale 1ns/1ps
package irq_fwd_pkg;

   localparam int unsigned IRQ_ID_W = 10;
   localparam logic [IRQ_ID_W-1:0] SPURIOUS_ID = 10'd1023;

   typedef enum logic {
      GRP_ZERO = 1'b0,
      GRP_ONE  = 1'b1
   } irq_grp_e;

   typedef enum int {
      ARB_TREE = 0,
      ARB_SCAN = 1
   } arb_style_e;

endpackage

// File: rtl/irq_fwd_elig.sv
`timescale 1ns/1ps
module irq_fwd_elig #(
   parameter int unsigned NUM_IRQ = 32
) (
   input  logic [NUM_IRQ-1:0] pend_i,
   input  logic [NUM_IRQ-1:0] en_i,
   output logic [NUM_IRQ-1:0] elig_o
);

   always_comb begin
      elig_o = pend_i & en_i;
   end

endmodule

// File: rtl/irq_fwd_arb.sv
`timescale 1ns/1ps
module irq_fwd_arb
   import irq_fwd_pkg::*;
#(
   parameter int unsigned NUM_IRQ   = 32,
   parameter int unsigned PRIO_W    = 8,
   parameter arb_style_e  ARB_STYLE = ARB_TREE
) (
   input  logic [NUM_IRQ-1:0]        elig_i,
   input  logic [NUM_IRQ-1:0]        grp_i,
   input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
   output logic                      win_v_o,
   output logic [IRQ_ID_W-1:0]       win_id_o,
   output logic [PRIO_W-1:0]         win_prio_o,
   output logic                      win_grp_o
);

   localparam int unsigned LEVELS = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 0;
   localparam int unsigned LEAVES = 1 << LEVELS;

   generate
      if (ARB_STYLE == ARB_TREE) begin : g_tree
         logic [LEAVES-1:0]        elig_pad;
         logic [LEAVES-1:0]        grp_pad;
         logic [LEAVES*PRIO_W-1:0] prio_pad;
         logic                     nv  [1:2*LEAVES-1];
         logic [IRQ_ID_W-1:0]      nid [1:2*LEAVES-1];
         logic [PRIO_W-1:0]        np  [1:2*LEAVES-1];
         logic                     ng  [1:2*LEAVES-1];

         always_comb begin
            elig_pad = LEAVES'(elig_i);
            grp_pad  = LEAVES'(grp_i);
            prio_pad = (LEAVES*PRIO_W)'(prio_i);
         end

         always_comb begin
            logic take_left;
            for (int i = 0; i < LEAVES; i++) begin
               nv[LEAVES+i]  = elig_pad[i];
               nid[LEAVES+i] = IRQ_ID_W'(i);
               np[LEAVES+i]  = prio_pad[i*PRIO_W +: PRIO_W];
               ng[LEAVES+i]  = grp_pad[i];
            end
            for (int k = LEAVES - 1; k >= 1; k--) begin
               // the left subtree holds lower IDs, so it keeps ties
               take_left = nv[2*k] && (!nv[2*k+1] || (np[2*k] <= np[2*k+1]));
               nv[k]  = nv[2*k] || nv[2*k+1];
               nid[k] = take_left ? nid[2*k] : nid[2*k+1];
               np[k]  = take_left ? np[2*k]  : np[2*k+1];
               ng[k]  = take_left ? ng[2*k]  : ng[2*k+1];
            end
            win_v_o    = nv[1];
            win_id_o   = nid[1];
            win_prio_o = np[1];
            win_grp_o  = ng[1];
         end
      end else begin : g_scan
         always_comb begin
            win_v_o    = 1'b0;
            win_id_o   = SPURIOUS_ID;
            win_prio_o = '1;
            win_grp_o  = 1'b0;
            for (int i = 0; i < NUM_IRQ; i++) begin
               if (elig_i[i] && (!win_v_o || (prio_i[i*PRIO_W +: PRIO_W] < win_prio_o))) begin
                  win_v_o    = 1'b1;
                  win_id_o   = IRQ_ID_W'(i);
                  win_prio_o = prio_i[i*PRIO_W +: PRIO_W];
                  win_grp_o  = grp_i[i];
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/irq_fwd_gate.sv
`timescale 1ns/1ps
module irq_fwd_gate
   import irq_fwd_pkg::*;
#(
   parameter int unsigned PRIO_W = 8
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                win_v_i,
   input  logic [IRQ_ID_W-1:0] win_id_i,
   input  logic [PRIO_W-1:0]   win_prio_i,
   input  logic                win_grp_i,
   input  logic                grp0_en_i,
   input  logic                grp1_en_i,
   output logic                fwd_valid_o,
   output logic [IRQ_ID_W-1:0] fwd_id_o,
   output logic [PRIO_W-1:0]   fwd_prio_o,
   output logic                fwd_group_o
);

   logic grp_open;
   logic pass;

   always_comb begin
      grp_open = (irq_grp_e'(win_grp_i) == GRP_ONE) ? grp1_en_i : grp0_en_i;
      pass     = win_v_i && grp_open;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni || !pass) begin
         fwd_valid_o <= 1'b0;
         fwd_id_o    <= SPURIOUS_ID;
         fwd_prio_o  <= '1;
         fwd_group_o <= 1'b0;
      end else begin
         fwd_valid_o <= 1'b1;
         fwd_id_o    <= win_id_i;
         fwd_prio_o  <= win_prio_i;
         fwd_group_o <= win_grp_i;
      end
   end

endmodule

// File: rtl/irq_fwd_dist.sv
`timescale 1ns/1ps
module irq_fwd_dist
   import irq_fwd_pkg::*;
#(
   parameter int unsigned NUM_IRQ   = 32,
   parameter int unsigned PRIO_W    = 8,
   parameter arb_style_e  ARB_STYLE = ARB_TREE
) (
   input  logic                      clk_i,
   input  logic                      rst_ni,
   input  logic [NUM_IRQ-1:0]        irq_pending_i,
   input  logic [NUM_IRQ-1:0]        irq_enable_i,
   input  logic [NUM_IRQ-1:0]        irq_group_i,
   input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio_i,
   input  logic                      grp0_en_i,
   input  logic                      grp1_en_i,
   output logic                      fwd_valid_o,
   output logic [9:0]                fwd_id_o,
   output logic [PRIO_W-1:0]         fwd_prio_o,
   output logic                      fwd_group_o
);

   generate
      if (NUM_IRQ < 1 || NUM_IRQ > 1023) begin : g_bad_num
         $error("irq_fwd_dist: NUM_IRQ must be 1..1023 so the spurious ID stays distinct");
      end
      if (PRIO_W < 1 || PRIO_W > 16) begin : g_bad_prio
         $error("irq_fwd_dist: PRIO_W must be 1..16");
      end
   endgenerate

   logic [NUM_IRQ-1:0]  elig;
   logic                win_v;
   logic [IRQ_ID_W-1:0] win_id;
   logic [PRIO_W-1:0]   win_prio;
   logic                win_grp;

   irq_fwd_elig #(.NUM_IRQ(NUM_IRQ)) elig_i (
      .pend_i (irq_pending_i),
      .en_i   (irq_enable_i),
      .elig_o (elig)
   );

   irq_fwd_arb #(
      .NUM_IRQ   (NUM_IRQ),
      .PRIO_W    (PRIO_W),
      .ARB_STYLE (ARB_STYLE)
   ) arb_i (
      .elig_i     (elig),
      .grp_i      (irq_group_i),
      .prio_i     (irq_prio_i),
      .win_v_o    (win_v),
      .win_id_o   (win_id),
      .win_prio_o (win_prio),
      .win_grp_o  (win_grp)
   );

   irq_fwd_gate #(.PRIO_W(PRIO_W)) gate_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .win_v_i     (win_v),
      .win_id_i    (win_id),
      .win_prio_i  (win_prio),
      .win_grp_i   (win_grp),
      .grp0_en_i   (grp0_en_i),
      .grp1_en_i   (grp1_en_i),
      .fwd_valid_o (fwd_valid_o),
      .fwd_id_o    (fwd_id_o),
      .fwd_prio_o  (fwd_prio_o),
      .fwd_group_o (fwd_group_o)
   );

endmodule

// File: rtl/irq_fwd_chk.sv
`timescale 1ns/1ps
module irq_fwd_chk #(
   parameter int unsigned NUM_IRQ = 32,
   parameter int unsigned PRIO_W  = 8
) (
   input logic                      clk_i,
   input logic                      rst_ni,
   input logic [NUM_IRQ-1:0]        irq_pending_i,
   input logic [NUM_IRQ-1:0]        irq_enable_i,
   input logic [NUM_IRQ-1:0]        irq_group_i,
   input logic [NUM_IRQ*PRIO_W-1:0] irq_prio_i,
   input logic                      grp0_en_i,
   input logic                      grp1_en_i,
   input logic                      fwd_valid_o,
   input logic [9:0]                fwd_id_o,
   input logic [PRIO_W-1:0]         fwd_prio_o,
   input logic                      fwd_group_o
);

   logic [NUM_IRQ-1:0]        elig_q;
   logic [NUM_IRQ-1:0]        grp_q;
   logic [NUM_IRQ*PRIO_W-1:0] prio_q;
   logic                      en0_q, en1_q;
   int unsigned               sel;
   logic                      sel_elig, sel_grp;
   logic [PRIO_W-1:0]         sel_prio;
   logic                      beaten;
   logic                      any_now;

   always_ff @(posedge clk_i) begin
      elig_q <= irq_pending_i & irq_enable_i;
      grp_q  <= irq_group_i;
      prio_q <= irq_prio_i;
      en0_q  <= grp0_en_i;
      en1_q  <= grp1_en_i;
   end

   always_comb begin
      sel      = (32'(fwd_id_o) < NUM_IRQ) ? 32'(fwd_id_o) : 0;
      sel_elig = elig_q[sel];
      sel_grp  = grp_q[sel];
      sel_prio = prio_q[sel*PRIO_W +: PRIO_W];
      beaten   = 1'b0;
      for (int i = 0; i < NUM_IRQ; i++) begin
         if (elig_q[i] && ((prio_q[i*PRIO_W +: PRIO_W] < fwd_prio_o) ||
             ((prio_q[i*PRIO_W +: PRIO_W] == fwd_prio_o) && (i < 32'(fwd_id_o))))) begin
            beaten = 1'b1;
         end
      end
      any_now = |(irq_pending_i & irq_enable_i);
   end

   AST_RESET_IDLE: assert property (@(posedge clk_i)
      !rst_ni |=> !fwd_valid_o && fwd_id_o == 10'd1023); // R1

   AST_WINNER_ELIGIBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fwd_valid_o |-> (32'(fwd_id_o) < NUM_IRQ) && sel_elig); // R2

   AST_NO_BETTER_CAND: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fwd_valid_o |-> !beaten && fwd_prio_o == sel_prio); // R3

   AST_BOTH_OFF_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!grp0_en_i && !grp1_en_i) |=> !fwd_valid_o); // R5

   AST_BOTH_ON_FORWARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grp0_en_i && grp1_en_i && any_now) |=> fwd_valid_o); // R6

   AST_GROUP_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fwd_valid_o |-> (fwd_group_o == sel_grp) && (sel_grp ? en1_q : en0_q)); // R7

   AST_IDLE_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !fwd_valid_o |-> fwd_id_o == 10'd1023 && (&fwd_prio_o) && !fwd_group_o); // R11

endmodule

bind irq_fwd_dist irq_fwd_chk #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) chk_i (.*);

// File: tb/irq_fwd_dist_tb_top.sv
`timescale 1ns/1ps
module irq_fwd_dist_tb_top;
   import irq_fwd_pkg::*;

   localparam int unsigned N  = 5;
   localparam int unsigned PW = 3;
   localparam int unsigned OUT_W = 1 + 10 + PW + 1;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    pend = '0, en = '0, grp = '0;
   logic [N*PW-1:0] prio = '0;
   logic            e0 = 1'b0, e1 = 1'b0;

   logic            t_v, s_v, t_g, s_g;
   logic [9:0]      t_id, s_id;
   logic [PW-1:0]   t_p, s_p;

   int checks = 0;
   int fails  = 0;

   always #4 clk = ~clk; // 8 ns period, 125 MHz

   irq_fwd_dist #(.NUM_IRQ(N), .PRIO_W(PW), .ARB_STYLE(ARB_TREE)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .irq_pending_i(pend), .irq_enable_i(en),
      .irq_group_i(grp), .irq_prio_i(prio), .grp0_en_i(e0), .grp1_en_i(e1),
      .fwd_valid_o(t_v), .fwd_id_o(t_id), .fwd_prio_o(t_p), .fwd_group_o(t_g));

   irq_fwd_dist #(.NUM_IRQ(N), .PRIO_W(PW), .ARB_STYLE(ARB_SCAN)) dut_scan_i (
      .clk_i(clk), .rst_ni(rst_n), .irq_pending_i(pend), .irq_enable_i(en),
      .irq_group_i(grp), .irq_prio_i(prio), .grp0_en_i(e0), .grp1_en_i(e1),
      .fwd_valid_o(s_v), .fwd_id_o(s_id), .fwd_prio_o(s_p), .fwd_group_o(s_g));

   localparam logic [OUT_W-1:0] IDLE = {1'b0, 10'd1023, {PW{1'b1}}, 1'b0};

   function automatic logic [OUT_W-1:0] pack(logic v, logic [9:0] id, logic [PW-1:0] p, logic g);
      return {v, id, p, g};
   endfunction

   // Reference: lowest priority value wins, lowest ID on ties, strict group gate
   function automatic logic [OUT_W-1:0] model(output string tag);
      int best = -1;
      for (int i = 0; i < N; i++) begin
         if (pend[i] && en[i]) begin
            if (best < 0 || prio[i*PW +: PW] < prio[best*PW +: PW]) best = i;
         end
      end
      if (!e0 && !e1) begin tag = "R5"; return IDLE; end
      if (best < 0)  begin tag = "R2"; return IDLE; end
      if (!e0 && !grp[best]) begin tag = "R7"; return IDLE; end
      if (!e1 && grp[best])  begin tag = "R8"; return IDLE; end
      tag = (e0 && e1) ? "R6" : "R9";
      return pack(1'b1, 10'(best), prio[best*PW +: PW], grp[best]);
   endfunction

   task automatic check(string tag, logic [OUT_W-1:0] act, logic [OUT_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic apply(logic [N-1:0] p_, logic [N-1:0] en_, logic [N-1:0] g_,
                        logic [N*PW-1:0] pr_, logic e0_, logic e1_);
      @(negedge clk);
      pend = p_; en = en_; grp = g_; prio = pr_; e0 = e0_; e1 = e1_;
   endtask

   task automatic check_both(string tag, logic [OUT_W-1:0] exp);
      check(tag, pack(t_v, t_id, t_p, t_g), exp);
      check(tag, pack(s_v, s_id, s_p, s_g), exp);
   endtask

   initial begin
      #(8 * 190000);
      fails++;
      $display("FAIL R10 watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      string tag;
      logic [OUT_W-1:0] exp;
      logic [OUT_W-1:0] prev;
      // R1: reset with every source armed and both groups open
      pend = '1; en = '1; e0 = 1'b1; e1 = 1'b1;
      repeat (3) @(negedge clk);
      check_both("R1", IDLE);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check_both("R1", IDLE);

      // R3: irq1 prio 5, irq3 prio 2 -> irq3
      apply(5'b01010, '1, '0, {3'd0, 3'd2, 3'd0, 3'd5, 3'd0}, 1'b1, 1'b1);
      @(negedge clk); check_both("R3", pack(1'b1, 10'd3, 3'd2, 1'b0));
      // R4: irq2 and irq4 both prio 3 -> irq2
      apply(5'b10100, '1, 5'b10100, {3'd3, 3'd0, 3'd3, 3'd0, 3'd0}, 1'b1, 1'b1);
      @(negedge clk); check_both("R4", pack(1'b1, 10'd2, 3'd3, 1'b1));
      // R7: top irq0 in group 0 (disabled), irq1 group 1 lower rank -> blocked
      apply(5'b00011, '1, 5'b00010, {3'd0, 3'd0, 3'd0, 3'd4, 3'd1}, 1'b0, 1'b1);
      @(negedge clk); check_both("R7", IDLE);
      // R8: top irq0 in group 1 (disabled), irq1 group 0 -> blocked
      apply(5'b00011, '1, 5'b00001, {3'd0, 3'd0, 3'd0, 3'd4, 3'd1}, 1'b1, 1'b0);
      @(negedge clk); check_both("R8", IDLE);
      // R9: top irq1 in enabled group 1
      apply(5'b00011, '1, 5'b00010, {3'd0, 3'd0, 3'd0, 3'd2, 3'd6}, 1'b0, 1'b1);
      @(negedge clk); check_both("R9", pack(1'b1, 10'd1, 3'd2, 1'b1));
      // R2: pending but individually disabled
      apply(5'b11111, 5'b00000, '0, '0, 1'b1, 1'b1);
      @(negedge clk); check_both("R2", IDLE);
      // R5: both groups off with a live candidate
      apply(5'b00100, '1, '0, '0, 1'b0, 1'b0);
      @(negedge clk); check_both("R5", IDLE);
      // R10: output holds until the next rising edge, then follows
      apply(5'b10000, '1, 5'b10000, {3'd7, 12'd0}, 1'b1, 1'b1);
      #1; check_both("R10", IDLE);
      @(negedge clk); check_both("R10", pack(1'b1, 10'd4, 3'd7, 1'b1));
      // R11: losing the group enable returns the outputs to idle values
      apply(5'b10000, '1, 5'b10000, {3'd7, 12'd0}, 1'b1, 1'b0);
      @(negedge clk); check_both("R11", IDLE);

      // Sweep: every pending/enable/group pattern, varied enables and priorities
      for (int v = 0; v < (1 << (3 * N)); v++) begin
         logic [N*PW-1:0] pr;
         logic [1:0] ge;
         for (int i = 0; i < N; i++) pr[i*PW +: PW] = PW'(v * 5 + i * 3 + (v >> 5));
         ge = 2'((v ^ (v >> 3) ^ (v >> 7)) & 3);
         apply(N'(v), N'(v >> N), N'(v >> (2 * N)), pr, ge[0], ge[1]);
         exp = model(tag);
         @(negedge clk);
         check_both(tag, exp);
         prev = exp;
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule